// File: doc/BRIEF.md
# Operating Mode and Clock-Source Controller

This block follows the power state of a small processor subsystem through five modes (reset, run, halt, sleep and debug) and decides which of four clock sources oscillate in each mode. The four sources are an internal oscillator, a low-speed oscillator, a high-speed oscillator and an external clock input. It also gates the processor clock and picks the source that feeds the system clock.

Single-cycle strobes from the processor drive it: halt, sleep and debug-return. A wake-up line and a debug interrupt drive it as well. Per-source run enables let software keep extra sources on in run, halt and debug. Per-source stop-in-sleep bits decide which sources keep running through sleep so that peripherals can keep working there. When the processor leaves sleep, the controller enables the system clock source one cycle before it opens the processor clock gate. A new clock selection takes effect only while the processor runs. During the switch, the outgoing source stays on for one extra cycle.

Top module: `pmu_mode_ctrl`

## Requirements
- R1: While rst_n is low, mode is 0 (reset), osc_en is 4'b0001, cpu_clk_gate is 0 and sysclk_sel is 0. At the first rising edge after release, mode becomes 1 (run) with sysclk_sel still 0.
- R2: In run, sleep_req moves mode to 3 (sleep). cpu_clk_gate is 0 in every sleep cycle.
- R3: In sleep, osc_en[i] equals the inverse of src_slp_stop[i] for every source. The selected system source is not forced on.
- R4: In run, halt_req moves mode to 2 (halt), and cpu_clk_gate is 0 in halt. In halt, wake_req returns mode to run, and cpu_clk_gate is 1 in the first run cycle.
- R5: In sleep, wake_req returns mode to run. In that first run cycle osc_en[sysclk_sel] is 1 and cpu_clk_gate is 0. In the following cycle cpu_clk_gate is 1. In run, wake_req has no effect.
- R6: dbg_irq in run, halt or sleep moves mode to 4 (debug). It takes priority over sleep_req, halt_req and wake_req in the same cycle. cpu_clk_gate is 1 in debug, except in the first cycle after leaving sleep.
- R7: In debug only dbg_ret has an effect, and it returns mode to run with sysclk_sel unchanged since debug entry. halt_req, sleep_req, wake_req and dbg_irq are ignored in debug.
- R8: When sleep_req and halt_req are both high in run, mode goes to sleep.
- R9: In run, halt and debug, osc_en equals src_run_en OR the one-hot bit of sysclk_sel. Select codes are 0 for the internal oscillator (bit 0), 1 for low speed (bit 1), 2 for high speed (bit 2) and 3 for the external input (bit 3).
- R10: In run, with no dbg_irq, sleep_req or halt_req, a clk_sel different from sysclk_sel is copied to sysclk_sel at the next edge. For that one following cycle, the previously selected source bit is also held on in osc_en.
- R11: A clk_sel value presented outside run, or together with a mode-change strobe in run, does not change sysclk_sel. It takes effect at the first edge of an undisturbed run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Halt instruction strobe |
| sleep_req | input | 1 | Sleep instruction strobe |
| wake_req | input | 1 | Wake-up / cancel signal |
| dbg_irq | input | 1 | Debug interrupt |
| dbg_ret | input | 1 | Debug-return strobe |
| clk_sel | input | 2 | Requested system clock source code |
| src_run_en | input | 4 | Extra sources kept on in run, halt and debug |
| src_slp_stop | input | 4 | 1 stops the source in sleep, 0 keeps it running |
| mode | output | 3 | Current mode: 0 reset, 1 run, 2 halt, 3 sleep, 4 debug |
| osc_en | output | 4 | Oscillator enables, bit per source |
| cpu_clk_gate | output | 1 | Processor clock gate open |
| sysclk_sel | output | 2 | System clock mux select in use |

## Verification
The hardest situation to reach is a clock-select change that arrives while the controller is not in an undisturbed run cycle. Such a change must be held off and then applied with its one-cycle overlap right after a return from sleep or debug, while the sleep-exit gate delay is also in force. Directed sequences park a new select value during sleep and debug, wake the controller, and watch the hold cycle and the overlap cycle fall on adjacent cycles. A seeded random phase then fires strobes of varying density together with select and enable changes, so that strobe collisions and back-to-back switches occur many times.

// File: rtl/pmu_mode_pkg.sv
package pmu_mode_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_RESET = 3'd0,
    MD_RUN   = 3'd1,
    MD_HALT  = 3'd2,
    MD_SLEEP = 3'd3,
    MD_DEBUG = 3'd4
  } mode_t;

  function automatic logic [NUM_SRC-1:0] src_bit(input logic [SEL_W-1:0] sel);
    logic [NUM_SRC-1:0] v;
    v = '0;
    v[sel] = 1'b1;
    return v;
  endfunction

  function automatic logic [NUM_SRC-1:0] awake_mask(
    input logic [NUM_SRC-1:0] run_en,
    input logic [SEL_W-1:0]   sel,
    input logic               overlap,
    input logic [SEL_W-1:0]   old_sel
  );
    logic [NUM_SRC-1:0] v;
    v = run_en | src_bit(sel);
    if (overlap) v = v | src_bit(old_sel);
    return v;
  endfunction
endpackage

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
  import pmu_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt_req,
  input  logic  sleep_req,
  input  logic  wake_req,
  input  logic  dbg_irq,
  input  logic  dbg_ret,
  output mode_t mode_q,
  output logic  run_quiet,
  output logic  leave_sleep,
  output logic  wake_hold_q
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MD_RESET: mode_d = MD_RUN;
      MD_RUN: begin
        if (dbg_irq)        mode_d = MD_DEBUG;
        else if (sleep_req) mode_d = MD_SLEEP;
        else if (halt_req)  mode_d = MD_HALT;
      end
      MD_HALT, MD_SLEEP: begin
        if (dbg_irq)       mode_d = MD_DEBUG;
        else if (wake_req) mode_d = MD_RUN;
      end
      MD_DEBUG: if (dbg_ret) mode_d = MD_RUN;
      default: mode_d = MD_RESET;
    endcase
  end

  assign run_quiet   = (mode_q == MD_RUN) && !dbg_irq && !sleep_req && !halt_req;
  assign leave_sleep = (mode_q == MD_SLEEP) && (mode_d != MD_SLEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MD_RESET;
      wake_hold_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      wake_hold_q <= leave_sleep;
    end
  end
endmodule

// File: rtl/pmu_clk_select.sv
module pmu_clk_select
  import pmu_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_quiet,
  input  logic [SEL_W-1:0] clk_sel,
  output logic [SEL_W-1:0] active_sel,
  output logic [SEL_W-1:0] old_sel,
  output logic             overlap,
  output logic             do_switch
);
  assign do_switch = run_quiet && (clk_sel != active_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_sel <= '0;
      old_sel    <= '0;
      overlap    <= 1'b0;
    end else begin
      overlap <= do_switch;
      if (do_switch) begin
        old_sel    <= active_sel;
        active_sel <= clk_sel;
      end
    end
  end
endmodule

// File: rtl/pmu_osc_gate.sv
module pmu_osc_gate
  import pmu_mode_pkg::*;
(
  input  mode_t              mode_q,
  input  logic               wake_hold_q,
  input  logic [SEL_W-1:0]   active_sel,
  input  logic [SEL_W-1:0]   old_sel,
  input  logic               overlap,
  input  logic [NUM_SRC-1:0] src_run_en,
  input  logic [NUM_SRC-1:0] src_slp_stop,
  output logic [NUM_SRC-1:0] osc_en,
  output logic               cpu_clk_gate
);
  always_comb begin
    unique case (mode_q)
      MD_RESET: osc_en = src_bit('0);
      MD_SLEEP: osc_en = ~src_slp_stop;
      default:  osc_en = awake_mask(src_run_en, active_sel, overlap, old_sel);
    endcase
  end

  assign cpu_clk_gate = ((mode_q == MD_RUN) || (mode_q == MD_DEBUG)) && !wake_hold_q;
endmodule

// File: rtl/pmu_mode_ctrl.sv
module pmu_mode_ctrl
  import pmu_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               sleep_req,
  input  logic               wake_req,
  input  logic               dbg_irq,
  input  logic               dbg_ret,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic [NUM_SRC-1:0] src_run_en,
  input  logic [NUM_SRC-1:0] src_slp_stop,
  output logic [MODE_W-1:0]  mode,
  output logic [NUM_SRC-1:0] osc_en,
  output logic               cpu_clk_gate,
  output logic [SEL_W-1:0]   sysclk_sel
);
  mode_t            mode_q;
  logic             run_quiet;
  logic             leave_sleep;
  logic             wake_hold_q;
  logic [SEL_W-1:0] active_sel;
  logic [SEL_W-1:0] old_sel;
  logic             overlap;
  logic             do_switch;

  pmu_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .sleep_req   (sleep_req),
    .wake_req    (wake_req),
    .dbg_irq     (dbg_irq),
    .dbg_ret     (dbg_ret),
    .mode_q      (mode_q),
    .run_quiet   (run_quiet),
    .leave_sleep (leave_sleep),
    .wake_hold_q (wake_hold_q)
  );

  pmu_clk_select u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_quiet  (run_quiet),
    .clk_sel    (clk_sel),
    .active_sel (active_sel),
    .old_sel    (old_sel),
    .overlap    (overlap),
    .do_switch  (do_switch)
  );

  pmu_osc_gate u_gate (
    .mode_q       (mode_q),
    .wake_hold_q  (wake_hold_q),
    .active_sel   (active_sel),
    .old_sel      (old_sel),
    .overlap      (overlap),
    .src_run_en   (src_run_en),
    .src_slp_stop (src_slp_stop),
    .osc_en       (osc_en),
    .cpu_clk_gate (cpu_clk_gate)
  );

  assign mode       = mode_q;
  assign sysclk_sel = active_sel;
endmodule

// File: rtl/pmu_mode_ctrl_chk.sv
module pmu_mode_ctrl_chk
  import pmu_mode_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               dbg_irq,
  input logic               dbg_ret,
  input logic [SEL_W-1:0]   clk_sel,
  input logic [MODE_W-1:0]  mode,
  input logic [NUM_SRC-1:0] osc_en,
  input logic               cpu_clk_gate,
  input logic [SEL_W-1:0]   sysclk_sel,
  input logic               leave_sleep,
  input logic               do_switch
);
  logic awake;
  assign awake = (mode == MD_RUN) || (mode == MD_HALT) || (mode == MD_DEBUG);

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RESET) |=> (mode == MD_RUN && sysclk_sel == '0)); // R1

  AST_SLEEP_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SLEEP) |-> !cpu_clk_gate); // R2

  AST_HALT_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HALT) |-> !cpu_clk_gate); // R4

  AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    leave_sleep |=> (!cpu_clk_gate && osc_en[sysclk_sel])); // R5

  AST_DEBUG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq && (mode == MD_RUN || mode == MD_HALT || mode == MD_SLEEP)) |=> (mode == MD_DEBUG)); // R6

  AST_DEBUG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_DEBUG && !dbg_ret) |=> (mode == MD_DEBUG)); // R7

  AST_SEL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    awake |-> osc_en[sysclk_sel]); // R9

  AST_SWITCH_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    do_switch |=> (osc_en[$past(sysclk_sel)] && sysclk_sel == $past(clk_sel))); // R10

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_RUN) |=> $stable(sysclk_sel)); // R11
endmodule

bind pmu_mode_ctrl pmu_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dbg_irq      (dbg_irq),
  .dbg_ret      (dbg_ret),
  .clk_sel      (clk_sel),
  .mode         (mode),
  .osc_en       (osc_en),
  .cpu_clk_gate (cpu_clk_gate),
  .sysclk_sel   (sysclk_sel),
  .leave_sleep  (leave_sleep),
  .do_switch    (do_switch)
);

// File: tb/pmu_mode_ctrl_test.sv
`timescale 1ns/100ps
module pmu_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt_req, sleep_req, wake_req, dbg_irq, dbg_ret;
  logic [1:0] clk_sel;
  logic [3:0] src_run_en, src_slp_stop;
  logic [2:0] mode;
  logic [3:0] osc_en;
  logic       cpu_clk_gate;
  logic [1:0] sysclk_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state
  int       m_mode;
  bit [1:0] m_sel, m_old;
  bit       m_ovl, m_hold;

  always #2.5 clk = ~clk;

  pmu_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .wake_req(wake_req), .dbg_irq(dbg_irq), .dbg_ret(dbg_ret), .clk_sel(clk_sel),
    .src_run_en(src_run_en), .src_slp_stop(src_slp_stop), .mode(mode),
    .osc_en(osc_en), .cpu_clk_gate(cpu_clk_gate), .sysclk_sel(sysclk_sel)
  );

  function automatic bit [3:0] bit_of(input bit [1:0] s);
    return 4'b0001 << s;
  endfunction

  function automatic bit [3:0] exp_osc();
    if (m_mode == 0) return 4'b0001;
    if (m_mode == 3) return ~src_slp_stop;
    return src_run_en | bit_of(m_sel) | (m_ovl ? bit_of(m_old) : 4'b0000);
  endfunction

  function automatic bit exp_gate();
    return (m_mode == 1 || m_mode == 4) && !m_hold;
  endfunction

  // advance the model by one edge using the inputs present before it
  task automatic model_edge();
    int  nm;
    bit  sw;
    sw = 1'b0;
    nm = m_mode;
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_old = 0; m_ovl = 0; m_hold = 0;
      return;
    end
    case (m_mode)
      0: nm = 1;
      1: begin
        if (dbg_irq) nm = 4;
        else if (sleep_req) nm = 3;
        else if (halt_req) nm = 2;
        else if (clk_sel != m_sel) sw = 1'b1;
      end
      2, 3: begin
        if (dbg_irq) nm = 4;
        else if (wake_req) nm = 1;
      end
      4: if (dbg_ret) nm = 1;
      default: nm = 0;
    endcase
    m_hold = (m_mode == 3) && (nm != 3);
    m_ovl  = sw;
    if (sw) begin m_old = m_sel; m_sel = clk_sel; end
    m_mode = nm;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tm, input string to, input string tg, input string ts);
    check(tm, "mode", mode, m_mode);
    check(to, "osc_en", osc_en, exp_osc());
    check(tg, "cpu_clk_gate", cpu_clk_gate, exp_gate());
    check(ts, "sysclk_sel", sysclk_sel, m_sel);
  endtask

  task automatic clear_strobes();
    halt_req = 0; sleep_req = 0; wake_req = 0; dbg_irq = 0; dbg_ret = 0;
  endtask

  // inputs already set after a negedge; take one edge and compare
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    compare_all(tag, tag, tag, tag);
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    #900000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_17A3));
    rst_n = 0; clear_strobes();
    clk_sel = 0; src_run_en = 0; src_slp_stop = 4'hF;
    m_mode = 0; m_sel = 0; m_old = 0; m_ovl = 0; m_hold = 0;
    @(negedge clk);
    step("R1");
    step("R1");
    rst_n = 1;
    step("R1");                          // RESET -> RUN
    check("R1", "mode after release", mode, 1);

    // R9 run enables
    src_run_en = 4'b0100; step("R9");
    check("R9", "osc_en run", osc_en, 4'b0101);

    // R10 switch to external with overlap
    clk_sel = 2'd3; step("R10");
    check("R10", "overlap osc", osc_en, 4'b1101);
    step("R10");
    check("R10", "after overlap", osc_en, 4'b1100);

    // R8 sleep wins over halt; R3 keep bits
    src_slp_stop = 4'b1101;
    sleep_req = 1; halt_req = 1; step("R8");
    check("R8", "sleep priority", mode, 3);
    check("R3", "sleep osc", osc_en, 4'b0010);
    check("R2", "sleep gate", cpu_clk_gate, 0);

    // R11 select parked during sleep
    clk_sel = 2'd1; step("R11");
    check("R11", "sel frozen sleep", sysclk_sel, 3);

    // R5 wake from sleep
    wake_req = 1; step("R5");
    check("R5", "wake mode", mode, 1);
    check("R5", "wake gate held", cpu_clk_gate, 0);
    check("R5", "wake src on", osc_en[3], 1);
    wake_req = 1; step("R5");           // pending select applies here too
    check("R5", "gate opens", cpu_clk_gate, 1);
    check("R11", "deferred sel", sysclk_sel, 1);

    // R4 halt and wake
    halt_req = 1; step("R4");
    check("R4", "halt mode", mode, 2);
    check("R4", "halt gate", cpu_clk_gate, 0);
    clk_sel = 2'd2; step("R11");
    wake_req = 1; step("R4");
    check("R4", "halt wake gate", cpu_clk_gate, 1);
    step("R11");

    // R6 debug wins; R7 ignores
    dbg_irq = 1; sleep_req = 1; halt_req = 1; step("R6");
    check("R6", "debug priority", mode, 4);
    clk_sel = 2'd0;
    wake_req = 1; sleep_req = 1; halt_req = 1; dbg_irq = 1; step("R7");
    check("R7", "debug ignores", mode, 4);
    check("R7", "debug sel", sysclk_sel, 2);
    dbg_ret = 1; step("R7");
    check("R7", "debug return", mode, 1);
    step("R10");

    // R6 from sleep: gate hold in first debug cycle
    sleep_req = 1; step("R2");
    dbg_irq = 1; wake_req = 1; step("R6");
    check("R6", "debug from sleep gate", cpu_clk_gate, 0);
    step("R6");
    check("R6", "debug gate", cpu_clk_gate, 1);
    dbg_ret = 1; step("R7");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int dens;
      dens = (i / 500) % 4 + 1;
      halt_req  = ($urandom % 8) < dens;
      sleep_req = ($urandom % 10) < dens;
      wake_req  = ($urandom % 4) < dens;
      dbg_irq   = ($urandom % 24) < dens;
      dbg_ret   = ($urandom % 6) < dens;
      if ($urandom % 4 == 0) clk_sel = 2'($urandom);
      if ($urandom % 8 == 0) src_run_en = 4'($urandom);
      if ($urandom % 8 == 0) src_slp_stop = 4'($urandom);
      if ($urandom % 997 == 0) rst_n = 0; else rst_n = 1;
      @(posedge clk);
      model_edge();
      #1;
      compare_all("R6", (m_mode == 3) ? "R3" : "R9", "R5", "R10");
      @(negedge clk);
    end
    rst_n = 1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule